// File: doc/BRIEF.md
# Trapezoid Wave Shaper for Square-Wave FSK Transmit

This block turns a square-wave FSK transmit bit stream, with tones near 1200 Hz and 2200 Hz carried as logic levels, into a stream of unsigned sample words for an external D/A converter. A clock enable at a fixed rate, well above the tone frequencies, steps a counter. The FSK level sets the counting direction: a high level counts up and a low level counts down. The count sticks at a programmable floor and a programmable ceiling, so it integrates the square wave and then clamps it. The words it produces trace a trapezoid. The D/A converter and its smoothing filter lie outside the block.

While transmit is off, the block captures the limit pins on every clock. A pair is accepted only when the floor is below the ceiling, and the count is preloaded to the midpoint of the accepted pair. A carrier burst therefore starts from the centre level. While transmit is on, the captured limits are frozen. A one-cycle strobe marks each step so that the converter can be paced from it. With the defaults the ramp spans 64 codes. At a step rate of about 64 steps per 2200 Hz half-cycle, a full swing completes within the shortest half period of about 227 µs.

A five-state phase machine tracks the waveform:
- IDLE: transmit is off and the count is preloaded.
- RISE: the count is climbing.
- TOP: the count is clamped at the ceiling.
- FALL: the count is descending.
- BOTTOM: the count is clamped at the floor.

The machine changes state only on a step cycle while transmit is on:
- An up step moves it to TOP if the count reaches the ceiling, otherwise to RISE.
- A down step moves it to BOTTOM if the count reaches the floor, otherwise to FALL.
- Any cycle with transmit off returns it to IDLE.

Top module: `trap_shaper`

## Requirements
- R1: While reset is asserted, `sample` equals the midpoint of the default limits (floor 96, ceiling 160, so 128) and `sample_vld` is 0.
- R2: On a clock edge with `tx_en` low and `lim_lo` < `lim_hi`, the pair is captured. After that edge `sample` equals floor((`lim_lo` + `lim_hi`) / 2).
- R3: On a clock edge with `tx_en` low and `lim_lo` >= `lim_hi`, the pair is rejected. The previously captured limits are kept and `sample` is reloaded to their midpoint.
- R4: While `tx_en` is high, changes on `lim_lo` and `lim_hi` have no effect on the clamp levels.
- R5: On an edge with `tx_en`, `step_en` and `fsk_bit` all high, `sample` rises by exactly 1 unless it already equals the ceiling, where it stays.
- R6: On an edge with `tx_en` and `step_en` high and `fsk_bit` low, `sample` falls by exactly 1 unless it already equals the floor, where it stays.
- R7: On an edge with `tx_en` high and `step_en` low, `sample` is unchanged.
- R8: `sample_vld` is 1 for exactly the cycle after an edge with both `tx_en` and `step_en` high, and 0 after every other edge. It rises together with the stepped `sample`.
- R9: Once out of reset, `sample` always lies between the captured floor and ceiling, inclusive. The phase machine is in TOP only when `sample` equals the ceiling, and in BOTTOM only when it equals the floor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | Constant-rate step enable |
| fsk_bit | input | 1 | Square-wave FSK level: 1 counts up, 0 counts down |
| tx_en | input | 1 | Transmit on; low preloads the midpoint and captures the limits |
| lim_lo | input | W (8) | Requested floor |
| lim_hi | input | W (8) | Requested ceiling |
| sample | output | W (8) | Unsigned sample word for the D/A converter |
| sample_vld | output | 1 | One-cycle strobe after each step |

## Verification
The assertions assume the following about the inputs:
- Every input is a clean binary level, synchronous to `clk`.
- Reset is held from time zero until after the first edge.
- The limit pins may carry any value, including rejected pairs, because the checker reads only the captured limits to judge the clamp.

The bench changes inputs only on falling edges. It drives both valid and rejected limit pairs. It moves the limit pins during transmit, drops step enables at random inside FSK half-periods of 58 and 106 steps, and narrows the span to a single code, so every property is exercised without breaking the stable-input assumption.

// File: rtl/trap_pkg.sv
package trap_pkg;

    // Phase of the trapezoid
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RISE,
        PH_TOP,
        PH_FALL,
        PH_BOTTOM
    } phase_t;

    // Command from the phase machine to the counter
    typedef enum logic [1:0] {
        CMD_HOLD,
        CMD_LOAD,
        CMD_UP,
        CMD_DOWN
    } cmd_t;

endpackage

// File: rtl/trap_limits.sv
module trap_limits #(
    parameter int W      = 8,
    parameter int LO_DEF = 96,
    parameter int HI_DEF = 160
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_en,
    input  logic [W-1:0] lim_lo,
    input  logic [W-1:0] lim_hi,
    output logic [W-1:0] lo_q,
    output logic [W-1:0] hi_q,
    output logic [W-1:0] mid_nxt
);
    localparam logic [W-1:0] LO_RST = W'(LO_DEF);
    localparam logic [W-1:0] HI_RST = W'(HI_DEF);

    logic         accept;
    logic [W-1:0] lo_sel;
    logic [W-1:0] hi_sel;
    logic [W:0]   span_sum;

    // A pair is taken only while transmit is off and it is ordered
    assign accept = !tx_en && (lim_lo < lim_hi);

    always_comb begin
        lo_sel   = accept ? lim_lo : lo_q;
        hi_sel   = accept ? lim_hi : hi_q;
        span_sum = {1'b0, lo_sel} + {1'b0, hi_sel};
        mid_nxt  = span_sum[W:1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= LO_RST;
            hi_q <= HI_RST;
        end else if (accept) begin
            lo_q <= lim_lo;
            hi_q <= lim_hi;
        end
    end

endmodule

// File: rtl/trap_phase_fsm.sv
module trap_phase_fsm
    import trap_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_en,
    input  logic         step_en,
    input  logic         fsk_bit,
    input  logic [W-1:0] count,
    input  logic [W-1:0] lo_q,
    input  logic [W-1:0] hi_q,
    output phase_t       phase,
    output cmd_t         cmd
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    phase_t phase_nxt;
    logic   at_hi;
    logic   at_lo;
    logic   near_hi;
    logic   near_lo;

    assign at_hi   = (count == hi_q);
    assign at_lo   = (count == lo_q);
    assign near_hi = (count >= (hi_q - ONE));
    assign near_lo = (count <= (lo_q + ONE));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            phase <= phase_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        phase_nxt = phase;
        if (!tx_en) begin
            phase_nxt = PH_IDLE;
        end else if (step_en) begin
            unique case (phase)
                PH_TOP:    phase_nxt = fsk_bit ? PH_TOP : (near_lo ? PH_BOTTOM : PH_FALL);
                PH_BOTTOM: phase_nxt = fsk_bit ? (near_hi ? PH_TOP : PH_RISE) : PH_BOTTOM;
                PH_IDLE,
                PH_RISE,
                PH_FALL:   phase_nxt = fsk_bit ? (near_hi ? PH_TOP : PH_RISE)
                                               : (near_lo ? PH_BOTTOM : PH_FALL);
                default:   phase_nxt = PH_IDLE;
            endcase
        end
    end

    // Output logic
    always_comb begin
        cmd = CMD_HOLD;
        if (!tx_en) begin
            cmd = CMD_LOAD;
        end else if (step_en) begin
            unique case (phase)
                PH_TOP:    cmd = fsk_bit ? CMD_HOLD : (at_lo ? CMD_HOLD : CMD_DOWN);
                PH_BOTTOM: cmd = fsk_bit ? (at_hi ? CMD_HOLD : CMD_UP) : CMD_HOLD;
                PH_IDLE,
                PH_RISE,
                PH_FALL:   cmd = fsk_bit ? (at_hi ? CMD_HOLD : CMD_UP)
                                         : (at_lo ? CMD_HOLD : CMD_DOWN);
                default:   cmd = CMD_HOLD;
            endcase
        end
    end

endmodule

// File: rtl/trap_ramp.sv
module trap_ramp
    import trap_pkg::*;
#(
    parameter int W       = 8,
    parameter int RST_VAL = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cmd_t         cmd,
    input  logic [W-1:0] mid_nxt,
    input  logic         strobe_in,
    output logic [W-1:0] count,
    output logic         vld
);
    localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] CNT_RST = W'(RST_VAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= CNT_RST;
            vld   <= 1'b0;
        end else begin
            vld <= strobe_in;
            unique case (cmd)
                CMD_LOAD: count <= mid_nxt;
                CMD_UP:   count <= count + ONE;
                CMD_DOWN: count <= count - ONE;
                default:  count <= count;
            endcase
        end
    end

endmodule

// File: rtl/trap_shaper.sv
module trap_shaper
    import trap_pkg::*;
#(
    parameter int W      = 8,
    parameter int LO_DEF = 96,
    parameter int HI_DEF = 160
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en,
    input  logic         fsk_bit,
    input  logic         tx_en,
    input  logic [W-1:0] lim_lo,
    input  logic [W-1:0] lim_hi,
    output logic [W-1:0] sample,
    output logic         sample_vld
);
    localparam int RST_MID = (LO_DEF + HI_DEF) / 2;

    logic [W-1:0] lo_q;
    logic [W-1:0] hi_q;
    logic [W-1:0] mid_nxt;
    phase_t       phase;
    cmd_t         cmd;

    trap_limits #(.W(W), .LO_DEF(LO_DEF), .HI_DEF(HI_DEF)) u_limits (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_en   (tx_en),
        .lim_lo  (lim_lo),
        .lim_hi  (lim_hi),
        .lo_q    (lo_q),
        .hi_q    (hi_q),
        .mid_nxt (mid_nxt)
    );

    trap_phase_fsm #(.W(W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_en   (tx_en),
        .step_en (step_en),
        .fsk_bit (fsk_bit),
        .count   (sample),
        .lo_q    (lo_q),
        .hi_q    (hi_q),
        .phase   (phase),
        .cmd     (cmd)
    );

    trap_ramp #(.W(W), .RST_VAL(RST_MID)) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .mid_nxt   (mid_nxt),
        .strobe_in (tx_en && step_en),
        .count     (sample),
        .vld       (sample_vld)
    );

endmodule

// File: rtl/trap_shaper_chk.sv
module trap_shaper_chk
    import trap_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         step_en,
    input logic         fsk_bit,
    input logic         tx_en,
    input logic [W-1:0] lim_lo,
    input logic [W-1:0] lim_hi,
    input logic [W-1:0] sample,
    input logic         sample_vld,
    input logic [W-1:0] lo_q,
    input logic [W-1:0] hi_q,
    input phase_t       phase
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // R2
    lim_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && (lim_lo < lim_hi)) |=> (lo_q == $past(lim_lo)) && (hi_q == $past(lim_hi)));

    // R3
    lim_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !(lim_lo < lim_hi)) |=> $stable(lo_q) && $stable(hi_q));

    // R4
    lim_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |=> $stable(lo_q) && $stable(hi_q));

    // R5
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && step_en && fsk_bit && (sample != hi_q)) |=> (sample == $past(sample) + ONE));

    // R5
    clamp_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && step_en && fsk_bit && (sample == hi_q)) |=> $stable(sample));

    // R6
    step_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && step_en && !fsk_bit && (sample != lo_q)) |=> (sample == $past(sample) - ONE));

    // R6
    clamp_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && step_en && !fsk_bit && (sample == lo_q)) |=> $stable(sample));

    // R7
    no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !step_en) |=> $stable(sample));

    // R8
    strobe_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && step_en) |=> sample_vld);

    // R8
    strobe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_en && step_en) |=> !sample_vld);

    // R9
    in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample >= lo_q) && (sample <= hi_q));

    // R9
    top_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TOP) |-> (sample == hi_q));

    // R9
    bottom_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_BOTTOM) |-> (sample == lo_q));

endmodule

bind trap_shaper trap_shaper_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_en    (step_en),
    .fsk_bit    (fsk_bit),
    .tx_en      (tx_en),
    .lim_lo     (lim_lo),
    .lim_hi     (lim_hi),
    .sample     (sample),
    .sample_vld (sample_vld),
    .lo_q       (lo_q),
    .hi_q       (hi_q),
    .phase      (phase)
);

// File: tb/sim_trap_shaper.sv
module sim_trap_shaper;

    logic       clk     = 1'b0;
    logic       rst_n   = 1'b0;
    logic       step_en = 1'b0;
    logic       fsk_bit = 1'b0;
    logic       tx_en   = 1'b0;
    logic [7:0] lim_lo  = 8'd0;
    logic [7:0] lim_hi  = 8'd0;
    logic [7:0] sample;
    logic       sample_vld;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;
    bit  run_model = 0;

    // Behavioural reference state
    int m_lo  = 96;
    int m_hi  = 160;
    int m_cnt = 128;
    bit m_vld = 0;

    always #2 clk = ~clk;

    trap_shaper u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (step_en),
        .fsk_bit    (fsk_bit),
        .tx_en      (tx_en),
        .lim_lo     (lim_lo),
        .lim_hi     (lim_hi),
        .sample     (sample),
        .sample_vld (sample_vld)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model, advanced at every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lo = 96; m_hi = 160; m_cnt = 128; m_vld = 0;
        end else if (!tx_en) begin
            if (int'(lim_lo) < int'(lim_hi)) begin
                m_lo = lim_lo;
                m_hi = lim_hi;
            end
            m_cnt = (m_lo + m_hi) / 2;
            m_vld = 0;
        end else begin
            m_vld = step_en;
            if (step_en) begin
                if (fsk_bit) begin
                    if (m_cnt < m_hi) m_cnt = m_cnt + 1;
                end else begin
                    if (m_cnt > m_lo) m_cnt = m_cnt - 1;
                end
            end
        end
    end

    // Per-cycle comparison against the model (R5 R6 R7 R8 R9)
    always @(negedge clk) begin
        if (rst_n && run_model) begin
            chk("R9 model sample", sample, m_cnt);
            chk("R8 model strobe", sample_vld, m_vld);
            chk("R9 range", int'(sample >= m_lo && sample <= m_hi), 1);
        end
    end

    // Drive one cycle from a falling edge, return at the next falling edge
    task automatic tick(input bit tx, input bit st, input bit fb, input int lo, input int hi);
        tx_en   = tx;
        step_en = st;
        fsk_bit = fb;
        lim_lo  = lo[7:0];
        lim_hi  = hi[7:0];
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset sample", sample, 128);
        chk("R1 reset strobe", sample_vld, 0);
        rst_n = 1'b1;
        run_model = 1;

        // Pins hold a rejected pair: defaults kept
        tick(0, 0, 0, 0, 0);
        chk("R3 rejected pair keeps default midpoint", sample, 128);

        tick(0, 0, 0, 10, 20);
        chk("R2 midpoint of 10..20", sample, 15);

        tick(0, 1, 0, 30, 30);
        chk("R3 equal pair rejected", sample, 15);
        chk("R8 no strobe while idle", sample_vld, 0);
        tick(0, 0, 0, 50, 40);
        chk("R3 reversed pair rejected", sample, 15);

        // Ramp up
        tick(1, 1, 1, 50, 40);
        chk("R8 strobe after step", sample_vld, 1);
        tick(1, 1, 1, 50, 40);
        tick(1, 1, 1, 50, 40);
        chk("R5 three up steps", sample, 18);

        for (int i = 0; i < 4; i++) tick(1, 0, 1, 50, 40);
        chk("R7 no step holds sample", sample, 18);
        chk("R8 strobe low without step", sample_vld, 0);

        for (int i = 0; i < 5; i++) tick(1, 1, 1, 50, 40);
        chk("R5 clamp at ceiling 20", sample, 20);

        // Limit pins move during transmit
        tick(1, 1, 1, 0, 255);
        tick(1, 1, 1, 0, 255);
        chk("R4 ceiling frozen during transmit", sample, 20);

        for (int i = 0; i < 15; i++) tick(1, 1, 0, 0, 255);
        chk("R6 clamp at floor 10", sample, 10);

        // FSK-like stream over span 40..104
        tick(0, 0, 0, 40, 104);
        chk("R2 midpoint of 40..104", sample, 72);
        begin
            bit fb = 1'b1;
            for (int b = 0; b < 40; b++) begin
                int half;
                half = (($urandom % 2) == 0) ? 58 : 106;
                for (int s = 0; s < half; s++) begin
                    tick(1, 1, fb, 0, 0);
                    if (($urandom % 4) == 0) tick(1, 0, fb, 0, 0);
                end
                fb = !fb;
            end
        end

        // One-code span boundary
        tick(0, 0, 0, 0, 1);
        chk("R2 midpoint of 0..1", sample, 0);
        tick(1, 1, 0, 0, 1);
        chk("R6 hold at floor 0", sample, 0);
        tick(1, 1, 1, 0, 1);
        chk("R5 one step to 1", sample, 1);
        tick(1, 1, 1, 0, 1);
        chk("R5 hold at ceiling 1", sample, 1);

        // Full range
        tick(0, 0, 0, 0, 255);
        chk("R2 midpoint of 0..255", sample, 127);
        tick(0, 0, 0, 254, 255);
        chk("R2 midpoint of 254..255", sample, 254);
        tick(1, 1, 1, 254, 255);
        tick(1, 1, 1, 254, 255);
        chk("R5 clamp at top code", sample, 255);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule